// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block places received frames into a circular buffer in local byte-addressed memory. The buffer is made of 256-byte pages and bounded by a first page and an end page; the end page is the first page past the ring. Frame bytes arrive as a stream with first-byte and last-byte markers. The block writes the payload into memory, starting four bytes into the current page, and jumps back to the first page of the ring whenever the write address reaches the end of the ring.

When the last byte is in, the block fills in the four-byte header that it left free at the start of the frame. The header holds a status code, the page where the next frame will begin, and the stored length. The block then moves its current-page pointer to that next page and pulses a receive interrupt. Separately, it compares the space between the current page and a boundary page owned by the host with the largest possible frame. From that it drives a ready flag, which the upstream source uses to decide whether a frame may start.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, cur_page is 0x00, mem_we is low and rx_irq is low.
- R2: The first payload byte, marked by rx_valid with rx_sof while the block is idle, goes to byte address cur_page*256+4. Each later byte with rx_valid goes to the following address.
- R3: When a payload byte has been written at end_page*256-1, the next payload byte goes to first_page*256.
- R4: The header goes to cur_page*256+0..3 in the four cycles right after the rx_eof byte. Its bytes are 0x01, then the next-frame page, then the low byte and then the high byte of the total length. The total length is the payload byte count plus 4.
- R5: The next-frame byte address is cur_page*256 + ((total+4+255) rounded down to a multiple of 256). If that address is at or past end_page*256, (end_page-first_page)*256 is subtracted from it.
- R6: The clock edge that writes the fourth header byte also loads the next-frame page into cur_page. rx_irq is then high for exactly the one cycle that follows.
- R7: cur_load with cur_wdata sets cur_page at the next edge, except at the edge where a frame updates it.
- R8: rx_ready is low whenever halted is high.
- R9: Free space is B-C when C<B. Otherwise it is (end_page-first_page)*256-(C-B), where C=cur_page*256 and B=bound_page*256. rx_ready is high only when free space is at least MAX_FRAME+4 (1518 by default).
- R10: While idle, rx_valid without rx_sof writes nothing and leaves cur_page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| first_page | input | 8 | First page of the ring |
| end_page | input | 8 | Page one past the last ring page |
| bound_page | input | 8 | Host-owned boundary page |
| halted | input | 1 | Receiver halted |
| cur_load | input | 1 | Load cur_page from cur_wdata |
| cur_wdata | input | 8 | Value for cur_page |
| rx_valid | input | 1 | Frame byte present |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Frame byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| cur_page | output | 8 | Current page pointer |
| rx_irq | output | 1 | One-cycle frame-stored pulse |
| rx_ready | output | 1 | Space available for a maximum frame |

## Verification
The hardest case to reach is a frame that crosses the end of the ring and also produces a next-frame address past the end, so that the subtraction of R5 takes effect. The bench gets there by loading cur_page with the last ring page through cur_load and then sending a frame longer than one page. Page-rounding edges come from frames of total length 252, 255 and 256 bytes. The ready threshold is approached from both sides by moving the boundary page one page at a time, with the boundary placed both ahead of and behind the current page.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned PG_W = 8;
  localparam int unsigned AD_W = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_HDR} wr_state_e;

  // One step forward in the ring, folding the end address back to the first page.
  function automatic logic [AD_W-1:0] ring_step(input logic [AD_W-1:0] a,
                                                input logic [PG_W-1:0] fp,
                                                input logic [PG_W-1:0] ep);
    logic [AD_W-1:0] n;
    n = a + AD_W'(1);
    if (n == {ep, 8'h00}) n = {fp, 8'h00};
    return n;
  endfunction

  // Page at which the following frame starts.
  function automatic logic [PG_W-1:0] next_page(input logic [PG_W-1:0] base,
                                                input logic [15:0] total,
                                                input logic [PG_W-1:0] fp,
                                                input logic [PG_W-1:0] ep);
    logic [17:0] span, nxt, lim, ring;
    span = ({2'b00, total} + 18'd259) & 18'h3FF00;
    nxt  = {2'b00, base, 8'h00} + span;
    lim  = {2'b00, ep, 8'h00};
    ring = {2'b00, ep, 8'h00} - {2'b00, fp, 8'h00};
    if (nxt >= lim) nxt = nxt - ring;
    return nxt[15:8];
  endfunction

  // Free bytes between the current page and the boundary page (may be negative).
  function automatic logic signed [18:0] ring_free(input logic [PG_W-1:0] cur,
                                                   input logic [PG_W-1:0] bnd,
                                                   input logic [PG_W-1:0] fp,
                                                   input logic [PG_W-1:0] ep);
    logic signed [18:0] c, b, f, e;
    c = $signed({3'b000, cur, 8'h00});
    b = $signed({3'b000, bnd, 8'h00});
    f = $signed({3'b000, fp, 8'h00});
    e = $signed({3'b000, ep, 8'h00});
    if (c < b) return b - c;
    return (e - f) - (c - b);
  endfunction
endpackage

// File: rtl/rxr_space_mon.sv
module rxr_space_mon
  import rxr_pkg::*;
#(
  parameter int unsigned MAX_FRAME = 1514
) (
  input  logic [PG_W-1:0] cur_page,
  input  logic [PG_W-1:0] bound_page,
  input  logic [PG_W-1:0] first_page,
  input  logic [PG_W-1:0] end_page,
  input  logic            halted,
  output logic            ready
);
  localparam logic signed [18:0] NEED = 19'(MAX_FRAME + 4);

  logic signed [18:0] free_bytes;

  always_comb begin
    free_bytes = ring_free(cur_page, bound_page, first_page, end_page);
    ready      = !halted && (free_bytes >= NEED);
  end
endmodule

// File: rtl/rxr_wr_ptr.sv
module rxr_wr_ptr
  import rxr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [AD_W-1:0] load_addr,
  input  logic            adv,
  input  logic [PG_W-1:0] first_page,
  input  logic [PG_W-1:0] end_page,
  output logic [AD_W-1:0] ptr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (load) ptr_q <= ring_step(load_addr, first_page, end_page);
    else if (adv)  ptr_q <= ring_step(ptr_q, first_page, end_page);
  end

  // R3: a payload write never lands on the end-of-ring address
  a_r3_no_end_addr: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> ptr_q != {end_page, 8'h00});
endmodule

// File: rtl/rxr_frame_ctl.sv
module rxr_frame_ctl
  import rxr_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_valid,
  input  logic            rx_sof,
  input  logic            rx_eof,
  input  logic [7:0]      rx_data,
  input  logic            cur_load,
  input  logic [PG_W-1:0] cur_wdata,
  input  logic [PG_W-1:0] first_page,
  input  logic [PG_W-1:0] end_page,
  input  logic [AD_W-1:0] ptr_q,
  output logic            ptr_load,
  output logic [AD_W-1:0] ptr_load_addr,
  output logic            ptr_adv,
  output logic            mem_we,
  output logic [AD_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  output logic [PG_W-1:0] cur_page,
  output logic            rx_irq
);
  localparam logic [7:0] STATUS_OK = 8'h01;

  wr_state_e        st_q;
  logic [PG_W-1:0]  base_q;
  logic [LEN_W-1:0] cnt_q;
  logic [1:0]       hidx_q;

  // named internal events
  logic             take_first, take_more, hdr_wr, hdr_last;
  logic [LEN_W-1:0] total_len;
  logic [PG_W-1:0]  nxt_pg;
  logic [7:0]       hdr_byte;

  always_comb begin
    take_first    = (st_q == ST_IDLE) && rx_valid && rx_sof;
    take_more     = (st_q == ST_DATA) && rx_valid;
    hdr_wr        = (st_q == ST_HDR);
    hdr_last      = hdr_wr && (hidx_q == 2'd3);
    total_len     = cnt_q + LEN_W'(4);
    nxt_pg        = next_page(base_q, 16'(total_len), first_page, end_page);
    ptr_load      = take_first;
    ptr_load_addr = {cur_page, 8'h04};
    ptr_adv       = take_more;
    case (hidx_q)
      2'd0:    hdr_byte = STATUS_OK;
      2'd1:    hdr_byte = nxt_pg;
      2'd2:    hdr_byte = total_len[7:0];
      default: hdr_byte = total_len[15:8];
    endcase
    mem_we    = take_first || take_more || hdr_wr;
    mem_wdata = hdr_wr ? hdr_byte : rx_data;
    if (take_first)  mem_addr = ptr_load_addr;
    else if (hdr_wr) mem_addr = {base_q, 6'b000000, hidx_q};
    else             mem_addr = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      base_q   <= '0;
      cnt_q    <= '0;
      hidx_q   <= '0;
      cur_page <= '0;
      rx_irq   <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      if (cur_load && !hdr_last) cur_page <= cur_wdata;
      case (st_q)
        ST_IDLE: if (take_first) begin
          base_q <= cur_page;
          cnt_q  <= LEN_W'(1);
          hidx_q <= '0;
          st_q   <= rx_eof ? ST_HDR : ST_DATA;
        end
        ST_DATA: if (take_more) begin
          cnt_q <= cnt_q + LEN_W'(1);
          if (rx_eof) st_q <= ST_HDR;
        end
        default: begin
          hidx_q <= hidx_q + 2'd1;
          if (hdr_last) begin
            cur_page <= nxt_pg;
            rx_irq   <= 1'b1;
            st_q     <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R6: interrupt is a single-cycle pulse
  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
  // R6: the page pointer moves on its own only together with the interrupt
  a_r6_page_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_page != $past(cur_page)) && !$past(cur_load) |-> rx_irq);
  // R4: the header write phase lasts four cycles and then releases
  a_r4_hdr_len: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hdr_last) |-> !hdr_wr);
  // R10: with no frame in progress and no start marker, nothing is written
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) && !(rx_valid && rx_sof) |-> !mem_we);
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int unsigned MAX_FRAME = 1514,
  parameter int unsigned LEN_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  first_page,
  input  logic [7:0]  end_page,
  input  logic [7:0]  bound_page,
  input  logic        halted,
  input  logic        cur_load,
  input  logic [7:0]  cur_wdata,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_data,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic [7:0]  cur_page,
  output logic        rx_irq,
  output logic        rx_ready
);
  logic            ptr_load, ptr_adv;
  logic [AD_W-1:0] ptr_load_addr, ptr_q;

  rxr_frame_ctl #(.LEN_W(LEN_W)) ctl_i (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .cur_load(cur_load), .cur_wdata(cur_wdata),
    .first_page(first_page), .end_page(end_page),
    .ptr_q(ptr_q), .ptr_load(ptr_load), .ptr_load_addr(ptr_load_addr),
    .ptr_adv(ptr_adv),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_page(cur_page), .rx_irq(rx_irq)
  );

  rxr_wr_ptr ptr_i (
    .clk(clk), .rst_n(rst_n),
    .load(ptr_load), .load_addr(ptr_load_addr), .adv(ptr_adv),
    .first_page(first_page), .end_page(end_page), .ptr_q(ptr_q)
  );

  rxr_space_mon #(.MAX_FRAME(MAX_FRAME)) space_i (
    .cur_page(cur_page), .bound_page(bound_page),
    .first_page(first_page), .end_page(end_page),
    .halted(halted), .ready(rx_ready)
  );

  // R8: a halted receiver never reports ready
  a_r8_halt_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !rx_ready);
  // R2: every write of a frame stays within the ring (valid ring configured)
  a_r2_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && (first_page < end_page) && (cur_page >= first_page) |->
      (mem_addr >= {first_page, 8'h00}) && (mem_addr < {end_page, 8'h00}));
endmodule

// File: tb/rx_ring_writer_tb_top.sv
module rx_ring_writer_tb_top;
  localparam int MAXF = 1514;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  first_page = 8'h40, end_page = 8'h80, bound_page = 8'h40;
  logic        halted = 1'b0, cur_load = 1'b0;
  logic [7:0]  cur_wdata = 8'h00;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        mem_we, rx_irq, rx_ready;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, cur_page;

  int vectors = 0, fails = 0;
  bit done = 0, cmp_on = 0;
  int wr_cnt = 0, irq_cnt = 0;
  byte unsigned bmem [int];
  int           bseq [int];

  always #4 clk = ~clk;

  rx_ring_writer dut_i (
    .clk(clk), .rst_n(rst_n), .first_page(first_page), .end_page(end_page),
    .bound_page(bound_page), .halted(halted), .cur_load(cur_load),
    .cur_wdata(cur_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cur_page(cur_page), .rx_irq(rx_irq),
    .rx_ready(rx_ready)
  );

  // local memory model capturing every write and its order
  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      bmem[int'(mem_addr)] = mem_wdata;
      bseq[int'(mem_addr)] = wr_cnt;
      wr_cnt++;
    end
    if (rst_n && rx_irq) irq_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int model_free(int cur, int bnd, int fp, int ep);
    int c, b;
    c = cur * 256; b = bnd * 256;
    if (c < b) return b - c;
    return (ep - fp) * 256 - (c - b);
  endfunction

  // R8 R9: ready compared against the reference on every clock
  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      bit exp_rdy;
      exp_rdy = !halted && (model_free(cur_page, bound_page, first_page, end_page) >= MAXF + 4);
      chk(rx_ready == exp_rdy, halted ? "R8" : "R9", rx_ready, exp_rdy);
    end
  end

  task automatic load_cur(input int pg);
    @(negedge clk); cur_load = 1'b1; cur_wdata = 8'(pg);
    @(negedge clk); cur_load = 1'b0;
  endtask

  task automatic send_frame(input int n, input int seed);
    int base, tot, nxt, exp_pg, a, irq0, lastseq;
    bit ok;
    base = cur_page;
    irq0 = irq_cnt;
    bmem.delete(); bseq.delete();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == n - 1);
      rx_data = 8'((seed + i * 7) & 8'hFF);
    end
    @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    repeat (6) @(negedge clk);
    tot = n + 4;
    nxt = base * 256 + ((tot + 4 + 255) / 256) * 256;
    if (nxt >= end_page * 256) nxt -= (end_page - first_page) * 256;
    exp_pg = nxt / 256;
    // payload, R2 and R3
    ok = 1; a = base * 256 + 4; lastseq = -1;
    for (int i = 0; i < n; i++) begin
      if (!bmem.exists(a) || bmem[a] != 8'((seed + i * 7) & 8'hFF)) ok = 0;
      else if (bseq[a] > lastseq) lastseq = bseq[a];
      a++;
      if (a >= end_page * 256) a -= (end_page - first_page) * 256;
    end
    chk(ok, (base * 256 + 4 + n > end_page * 256) ? "R3" : "R2", ok, 1);
    // header, R4 and R5
    a = base * 256;
    chk(bmem.exists(a) && bmem[a] == 8'h01, "R4", bmem.exists(a) ? bmem[a] : -1, 1);
    chk(bmem.exists(a + 1) && bmem[a + 1] == 8'(exp_pg), "R5",
        bmem.exists(a + 1) ? bmem[a + 1] : -1, exp_pg);
    chk(bmem.exists(a + 2) && bmem.exists(a + 3) &&
        {bmem[a + 3], bmem[a + 2]} == 16'(tot), "R4",
        bmem.exists(a + 2) ? bmem[a + 2] : -1, tot);
    chk(bseq.exists(a) && bseq[a] > lastseq, "R4", bseq.exists(a) ? bseq[a] : -1, lastseq + 1);
    // R6
    chk(cur_page == 8'(exp_pg), "R6", cur_page, exp_pg);
    chk(irq_cnt == irq0 + 1, "R6", irq_cnt - irq0, 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int w0, p0, seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cur_page == 8'h00, "R1", cur_page, 0);
    chk(mem_we == 1'b0, "R1", mem_we, 0);
    chk(rx_irq == 1'b0, "R1", rx_irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1;
    // R7 host load
    load_cur(8'h55);
    chk(cur_page == 8'h55, "R7", cur_page, 8'h55);
    load_cur(8'h40);
    chk(cur_page == 8'h40, "R7", cur_page, 8'h40);
    // frames of several sizes, incl. page-rounding edges
    send_frame(60, 3);
    send_frame(1, 9);
    send_frame(248, 17);
    send_frame(251, 33);
    send_frame(252, 5);
    // ring wrap of payload and of next page
    load_cur(8'h7F);
    send_frame(300, 71);
    load_cur(8'h7E);
    send_frame(600, 12);
    // R10 idle bytes without start marker
    w0 = wr_cnt; p0 = cur_page;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'(i);
    end
    @(negedge clk); rx_valid = 1'b0;
    @(negedge clk);
    chk(wr_cnt == w0, "R10", wr_cnt - w0, 0);
    chk(cur_page == 8'(p0), "R10", cur_page, p0);
    // R9 threshold, boundary ahead of current page
    load_cur(8'h41);
    @(negedge clk); bound_page = 8'h46;
    @(negedge clk); chk(rx_ready == 1'b0, "R9", rx_ready, 0);
    bound_page = 8'h47;
    @(negedge clk); chk(rx_ready == 1'b1, "R9", rx_ready, 1);
    // R9 boundary behind current page
    load_cur(8'h7C); bound_page = 8'h41;
    @(negedge clk); chk(rx_ready == 1'b0, "R9", rx_ready, 0);
    bound_page = 8'h42;
    @(negedge clk); chk(rx_ready == 1'b1, "R9", rx_ready, 1);
    // R8 halted
    halted = 1'b1;
    @(negedge clk); chk(rx_ready == 1'b0, "R8", rx_ready, 0);
    halted = 1'b0;
    @(negedge clk); chk(rx_ready == 1'b1, "R8", rx_ready, 1);
    seen = irq_cnt;
    repeat (3) @(negedge clk);
    chk(irq_cnt == seen, "R6", irq_cnt - seen, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule